// File: doc/BRIEF.md
# System bus address router

This block sits between an 8-bit processor with a 16-bit address bus and the memories and peripheral groups around it. For each read or write it raises exactly one target select, passes the target's read byte back to the processor, and forms the physical addresses for the banked work RAM and the high RAM. Reads and writes that hit no target return 0xFF and have no effect.

It also holds a few small control registers itself:
- the boot-overlay disable byte;
- the work-RAM bank number;
- the interrupt request and interrupt enable bytes;
- the input-select byte.

While the overlay byte is zero, reads in the lowest 256 bytes come from a boot ROM rather than the cartridge. The upper half of the work-RAM window is paged by the bank register. A further 4 KiB window repeats the fixed lower half of work RAM.

Decoding and the read mux are combinational, so a target answers in the same cycle as the access. The local registers are written on the clock edge that ends a write cycle. A write to the video DMA address does not select the video registers. It raises a one-cycle start strobe instead.

Top module: `sys_addr_router`

## Requirements
- R1: A read in 0x0000–0x00FF selects the boot ROM while the overlay register (0xFF50) is zero, and selects the cartridge once it is nonzero. Writes in 0x0000–0x00FF always select the cartridge.
- R2: The following regions select the cartridge: 0x0100–0x7FFF and 0xA000–0xBFFF. The following regions select video: 0x8000–0x9FFF, 0xFE00–0xFE9F and 0xFF40–0xFF4B.
- R3: 0xC000–0xCFFF selects work RAM with physical address = address − 0xC000.
- R4: 0xD000–0xDFFF selects work RAM with physical address = (address − 0xD000) + bank × 0x1000, where a stored bank of 0 is used as bank 1. The bank register at 0xFF70 keeps the low 3 bits of the written byte and reads back with the upper bits zero.
- R5: 0xE000–0xEFFF selects work RAM with physical address = address − 0xE000. The range 0xF000–0xFDFF is unmapped.
- R6: 0xFF01–0xFF02 selects serial and 0xFF04–0xFF07 selects the timer. Both 0xFF10–0xFF26 and 0xFF30–0xFF3F select sound.
- R7: The following locations are read/write bytes that drive the matching output ports: 0xFF0F (interrupt request), 0xFFFF (interrupt enable) and 0xFF00 (input select).
- R8: 0xFF80–0xFFFE selects high RAM with address = address − 0xFF80.
- R9: A write to 0xFF46 raises dma_start for that cycle and selects no target. A read of 0xFF46 selects video.
- R10: A read of an unmapped address returns 0xFF. A write to one selects nothing and changes no local register.
- R11: At most one select is high, and a select is high only during a read or write. cpu_rdata is the selected target's read byte.
- R12: After reset all local registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read cycle |
| cpu_wr | input | 1 | Write cycle |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte returned to processor |
| boot_sel | output | 1 | Boot ROM select |
| boot_rdata | input | 8 | Boot ROM read byte |
| cart_sel | output | 1 | Cartridge select |
| cart_rdata | input | 8 | Cartridge read byte |
| vid_sel | output | 1 | Video memory, attribute memory or video register select |
| vid_rdata | input | 8 | Video read byte |
| wram_sel | output | 1 | Work RAM select |
| wram_addr | output | 15 | Physical work-RAM address |
| wram_rdata | input | 8 | Work RAM read byte |
| hram_sel | output | 1 | High RAM select |
| hram_addr | output | 7 | High RAM address |
| hram_rdata | input | 8 | High RAM read byte |
| ser_sel | output | 1 | Serial group select |
| ser_rdata | input | 8 | Serial read byte |
| tmr_sel | output | 1 | Timer group select |
| tmr_rdata | input | 8 | Timer read byte |
| snd_sel | output | 1 | Sound group select |
| snd_rdata | input | 8 | Sound read byte |
| dma_start | output | 1 | Strobe on a write to 0xFF46 |
| irq_flags | output | 8 | Interrupt request register |
| irq_enable | output | 8 | Interrupt enable register |
| key_select | output | 8 | Input-select register |

## Verification
Directed cases hit both ends of every mapped region and the first unmapped byte next to it. A decoder with a boundary off by one would leave a select low, or raise a select on a hole that should read 0xFF. The overlay is tested before and after it is disabled, and with writes while it is still active. A design that steered writes into the boot ROM, or ignored the disable byte, would show the wrong select. The banked window is tested with bank 0, with a normal bank, and with a written byte whose upper bits are set. Taking bank 0 literally would alias the fixed half, and keeping extra bits would break the readback. Seeded random traffic, biased toward the top page, checks the DMA address in both directions and confirms that writes to holes leave every register port unchanged.

// File: rtl/sys_addr_router.sv
module sys_addr_router #(
  parameter int BANK_W = 3,
  localparam int WRAM_AW = BANK_W + 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  output logic               boot_sel,
  input  logic [7:0]         boot_rdata,
  output logic               cart_sel,
  input  logic [7:0]         cart_rdata,
  output logic               vid_sel,
  input  logic [7:0]         vid_rdata,
  output logic               wram_sel,
  output logic [WRAM_AW-1:0] wram_addr,
  input  logic [7:0]         wram_rdata,
  output logic               hram_sel,
  output logic [6:0]         hram_addr,
  input  logic [7:0]         hram_rdata,
  output logic               ser_sel,
  input  logic [7:0]         ser_rdata,
  output logic               tmr_sel,
  input  logic [7:0]         tmr_rdata,
  output logic               snd_sel,
  input  logic [7:0]         snd_rdata,
  output logic               dma_start,
  output logic [7:0]         irq_flags,
  output logic [7:0]         irq_enable,
  output logic [7:0]         key_select
);

  localparam logic [15:0] A_KEY  = 16'hFF00;
  localparam logic [15:0] A_IRQF = 16'hFF0F;
  localparam logic [15:0] A_DMA  = 16'hFF46;
  localparam logic [15:0] A_BOOT = 16'hFF50;
  localparam logic [15:0] A_BANK = 16'hFF70;
  localparam logic [15:0] A_IRQE = 16'hFFFF;

  logic              access;
  logic [7:0]        boot_off;
  logic [BANK_W-1:0] bank;
  logic [BANK_W-1:0] eff_bank;
  logic              in_low, boot_hit, cart_hit, vram_hit, oam_hit, vreg_hit;
  logic              wlo_hit, whi_hit, hram_hit, ser_hit, tmr_hit, snd_hit;
  logic              loc_hit;

  assign access   = cpu_rd | cpu_wr;
  assign in_low   = cpu_addr[15:8] == 8'h00;
  assign boot_hit = in_low & cpu_rd & (boot_off == 8'h00);
  assign cart_hit = (~cpu_addr[15] & ~boot_hit) | (cpu_addr[15:13] == 3'b101);
  assign vram_hit = cpu_addr[15:13] == 3'b100;
  assign oam_hit  = (cpu_addr[15:8] == 8'hFE) & (cpu_addr[7:0] <= 8'h9F);
  assign vreg_hit = (cpu_addr[15:4] == 12'hFF4) & (cpu_addr[3:0] <= 4'hB)
                    & ~(cpu_wr & (cpu_addr == A_DMA));
  assign wlo_hit  = (cpu_addr[15:12] == 4'hC) | (cpu_addr[15:12] == 4'hE);
  assign whi_hit  = cpu_addr[15:12] == 4'hD;
  assign hram_hit = (cpu_addr[15:7] == 9'h1FF) & (cpu_addr != A_IRQE);
  assign ser_hit  = (cpu_addr == 16'hFF01) | (cpu_addr == 16'hFF02);
  assign tmr_hit  = cpu_addr[15:2] == 14'h3FC1;
  assign snd_hit  = ((cpu_addr >= 16'hFF10) & (cpu_addr <= 16'hFF26))
                    | (cpu_addr[15:4] == 12'hFF3);
  assign loc_hit  = (cpu_addr == A_KEY) | (cpu_addr == A_IRQF) | (cpu_addr == A_BOOT)
                    | (cpu_addr == A_BANK) | (cpu_addr == A_IRQE);

  assign boot_sel = boot_hit;
  assign cart_sel = access & cart_hit;
  assign vid_sel  = access & (vram_hit | oam_hit | vreg_hit);
  assign wram_sel = access & (wlo_hit | whi_hit);
  assign hram_sel = access & hram_hit;
  assign ser_sel  = access & ser_hit;
  assign tmr_sel  = access & tmr_hit;
  assign snd_sel  = access & snd_hit;
  assign dma_start = cpu_wr & (cpu_addr == A_DMA);

  assign eff_bank  = (bank == '0) ? BANK_W'(1) : bank;
  assign wram_addr = whi_hit ? {eff_bank, cpu_addr[11:0]} : {{BANK_W{1'b0}}, cpu_addr[11:0]};
  assign hram_addr = cpu_addr[6:0];

  always_comb begin
    cpu_rdata = 8'hFF;
    if (cpu_rd) begin
      if (boot_sel)      cpu_rdata = boot_rdata;
      else if (cart_sel) cpu_rdata = cart_rdata;
      else if (vid_sel)  cpu_rdata = vid_rdata;
      else if (wram_sel) cpu_rdata = wram_rdata;
      else if (hram_sel) cpu_rdata = hram_rdata;
      else if (ser_sel)  cpu_rdata = ser_rdata;
      else if (tmr_sel)  cpu_rdata = tmr_rdata;
      else if (snd_sel)  cpu_rdata = snd_rdata;
      else if (loc_hit) begin
        case (cpu_addr)
          A_KEY:   cpu_rdata = key_select;
          A_IRQF:  cpu_rdata = irq_flags;
          A_BOOT:  cpu_rdata = boot_off;
          A_BANK:  cpu_rdata = 8'(bank);
          default: cpu_rdata = irq_enable;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_off   <= '0;
      bank       <= '0;
      irq_flags  <= '0;
      irq_enable <= '0;
      key_select <= '0;
    end else if (cpu_wr) begin
      case (cpu_addr)
        A_KEY:   key_select <= cpu_wdata;
        A_IRQF:  irq_flags  <= cpu_wdata;
        A_BOOT:  boot_off   <= cpu_wdata;
        A_BANK:  bank       <= cpu_wdata[BANK_W-1:0];
        A_IRQE:  irq_enable <= cpu_wdata;
        default: ;
      endcase
    end
  end

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({boot_sel, cart_sel, vid_sel, wram_sel, hram_sel, ser_sel, tmr_sel, snd_sel}));

  // R11
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !access |-> !(boot_sel | cart_sel | vid_sel | wram_sel | hram_sel | ser_sel | tmr_sel | snd_sel));

  // R9
  dma_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> !vid_sel && !cart_sel && !wram_sel);

  // R1
  boot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_sel |-> cpu_rd && !cpu_wr && cpu_addr < 16'h0100);

  // R4
  bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wram_sel && cpu_addr[15:12] == 4'hD) |-> wram_addr[WRAM_AW-1:12] != '0);

  // R4
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == A_BANK) |=> bank == $past(cpu_wdata[BANK_W-1:0]));

  // R10
  hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !loc_hit) |=> $stable(irq_flags) && $stable(irq_enable) && $stable(key_select));

endmodule

// File: tb/test_sys_addr_router.sv
module test_sys_addr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        boot_sel, cart_sel, vid_sel, wram_sel, hram_sel, ser_sel, tmr_sel, snd_sel;
  logic [14:0] wram_addr;
  logic [6:0]  hram_addr;
  logic        dma_start;
  logic [7:0]  irq_flags, irq_enable, key_select;

  localparam logic [7:0] D_BOOT = 8'hB0, D_CART = 8'hCA, D_VID = 8'h71, D_WRAM = 8'h3A;
  localparam logic [7:0] D_HRAM = 8'h4E, D_SER = 8'h5E, D_TMR = 8'h7E, D_SND = 8'h50;

  always #10 clk = ~clk;

  sys_addr_router i_sys_addr_router (
    .clk, .rst_n, .cpu_addr, .cpu_rd, .cpu_wr, .cpu_wdata, .cpu_rdata,
    .boot_sel, .boot_rdata(D_BOOT), .cart_sel, .cart_rdata(D_CART),
    .vid_sel, .vid_rdata(D_VID), .wram_sel, .wram_addr, .wram_rdata(D_WRAM),
    .hram_sel, .hram_addr, .hram_rdata(D_HRAM), .ser_sel, .ser_rdata(D_SER),
    .tmr_sel, .tmr_rdata(D_TMR), .snd_sel, .snd_rdata(D_SND),
    .dma_start, .irq_flags, .irq_enable, .key_select
  );

  int checks = 0, fails = 0;
  logic [7:0] m_if = 0, m_ie = 0, m_key = 0, m_boot = 0;
  logic [2:0] m_bank = 0;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s at %h: got %h expected %h", tag, what, cpu_addr, got, exp);
    end
  endtask

  // select vector order: boot cart vid wram hram ser tmr snd
  function automatic logic [7:0] exp_sel(input logic [15:0] a, input logic rd, input logic wr);
    if (!(rd || wr)) return 8'h00;
    if (a <= 16'h00FF && rd && m_boot == 0) return 8'h80;
    if (a <= 16'h7FFF) return 8'h40;
    if (a <= 16'h9FFF) return 8'h20;
    if (a <= 16'hBFFF) return 8'h40;
    if (a <= 16'hEFFF) return 8'h10;
    if (a >= 16'hFE00 && a <= 16'hFE9F) return 8'h20;
    if (a == 16'hFF01 || a == 16'hFF02) return 8'h04;
    if (a >= 16'hFF04 && a <= 16'hFF07) return 8'h02;
    if ((a >= 16'hFF10 && a <= 16'hFF26) || (a >= 16'hFF30 && a <= 16'hFF3F)) return 8'h01;
    if (a >= 16'hFF40 && a <= 16'hFF4B && !(a == 16'hFF46 && wr)) return 8'h20;
    if (a >= 16'hFF80 && a <= 16'hFFFE) return 8'h08;
    return 8'h00;
  endfunction

  function automatic int exp_wram(input logic [15:0] a);
    int b;
    b = (m_bank == 0) ? 1 : int'(m_bank);
    if (a >= 16'hD000 && a <= 16'hDFFF) return b * 4096 + int'(a) - 'hD000;
    if (a >= 16'hE000) return int'(a) - 'hE000;
    return int'(a) - 'hC000;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic [7:0] s);
    case (s)
      8'h80: return D_BOOT;
      8'h40: return D_CART;
      8'h20: return D_VID;
      8'h10: return D_WRAM;
      8'h08: return D_HRAM;
      8'h04: return D_SER;
      8'h02: return D_TMR;
      8'h01: return D_SND;
      default: ;
    endcase
    case (a)
      16'hFF00: return m_key;
      16'hFF0F: return m_if;
      16'hFF50: return m_boot;
      16'hFF70: return {5'b0, m_bank};
      16'hFFFF: return m_ie;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic access(input logic [15:0] a, input logic rd, input logic wr,
                        input logic [7:0] wd, input string tag);
    logic [7:0] es;
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    #5;
    es = exp_sel(a, rd, wr);
    chk(tag, "selects", {boot_sel, cart_sel, vid_sel, wram_sel, hram_sel, ser_sel, tmr_sel, snd_sel}, es);
    chk(tag, "dma_start", dma_start, (wr && a == 16'hFF46) ? 1 : 0);
    if (es == 8'h10) chk(tag, "wram_addr", wram_addr, exp_wram(a));
    if (es == 8'h08) chk(tag, "hram_addr", hram_addr, int'(a) - 'hFF80);
    if (rd) chk(tag, "rdata", cpu_rdata, exp_rd(a, es));
    chk(tag, "irq/key regs", {irq_flags, irq_enable, key_select}, {m_if, m_ie, m_key});
    if (wr) begin
      case (a)
        16'hFF00: m_key = wd;
        16'hFF0F: m_if = wd;
        16'hFF50: m_boot = wd;
        16'hFF70: m_bank = wd[2:0];
        16'hFFFF: m_ie = wd;
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [15:0] a, input string tag); access(a, 1, 0, 8'h00, tag); endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag); access(a, 0, 1, d, tag); endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] a;
    int kind;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    rd(16'hFF0F, "R12"); rd(16'hFFFF, "R12"); rd(16'hFF00, "R12");
    rd(16'hFF50, "R12"); rd(16'hFF70, "R12");
    access(16'h1234, 0, 0, 8'h00, "R11");
    // R1 overlay
    rd(16'h0000, "R1"); rd(16'h00FF, "R1"); rd(16'h0100, "R1");
    wr(16'h0010, 8'h55, "R1");
    wr(16'hFF50, 8'h01, "R1");
    rd(16'h0010, "R1"); rd(16'hFF50, "R1");
    // R2 boundaries
    rd(16'h7FFF, "R2"); rd(16'h8000, "R2"); rd(16'h9FFF, "R2"); rd(16'hA000, "R2");
    rd(16'hBFFF, "R2"); rd(16'hFE00, "R2"); rd(16'hFE9F, "R2"); rd(16'hFF40, "R2");
    rd(16'hFF4B, "R2"); rd(16'hFEA0, "R10"); rd(16'hFF4C, "R10");
    // R3 / R4 / R5
    rd(16'hC123, "R3"); rd(16'hCFFF, "R3");
    rd(16'hD456, "R4");
    wr(16'hFF70, 8'h05, "R4"); rd(16'hD456, "R4"); rd(16'hFF70, "R4");
    wr(16'hFF70, 8'hFA, "R4"); rd(16'hFF70, "R4"); wr(16'hDFFF, 8'h11, "R4");
    rd(16'hE123, "R5"); rd(16'hEFFF, "R5"); rd(16'hF000, "R5"); rd(16'hFDFF, "R5");
    // R6
    rd(16'hFF01, "R6"); rd(16'hFF02, "R6"); rd(16'hFF03, "R6"); rd(16'hFF04, "R6");
    rd(16'hFF07, "R6"); rd(16'hFF08, "R6"); rd(16'hFF10, "R6"); rd(16'hFF26, "R6");
    rd(16'hFF27, "R6"); rd(16'hFF30, "R6"); rd(16'hFF3F, "R6");
    // R7
    wr(16'hFF0F, 8'h1F, "R7"); rd(16'hFF0F, "R7");
    wr(16'hFFFF, 8'hA5, "R7"); rd(16'hFFFF, "R7");
    wr(16'hFF00, 8'h30, "R7"); rd(16'hFF00, "R7");
    // R8
    rd(16'hFF80, "R8"); rd(16'hFFFE, "R8"); wr(16'hFFC3, 8'h99, "R8");
    // R9
    wr(16'hFF46, 8'hC0, "R9"); rd(16'hFF46, "R9"); wr(16'hFF45, 8'h01, "R9");
    // R10
    wr(16'hF000, 8'h77, "R10"); wr(16'hFF03, 8'h77, "R10"); rd(16'hFF7F, "R10");
    // R11 random traffic
    for (int i = 0; i < 4000; i++) begin
      kind = $urandom % 6;
      case (kind)
        0: a = 16'($urandom);
        1, 2: a = {8'hFF, 8'($urandom)};
        3: a = {8'hFE, 8'($urandom)};
        4: a = 16'hC000 + 16'($urandom % 16'h3000);
        default: a = {8'h00, 8'($urandom)};
      endcase
      if (a == 16'hFF50 && ($urandom % 4) != 0) a = 16'hFF70;
      case ($urandom % 3)
        0: access(a, 1, 0, 8'h00, "R11");
        1: access(a, 0, 1, 8'($urandom), "R11");
        default: access(a, 0, 0, 8'h00, "R11");
      endcase
    end
    @(negedge clk); cpu_rd = 0; cpu_wr = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule